// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets clocked logic read and write an external 128K x 8 asynchronous static RAM. The system side has a valid/ready request port that carries a write flag, a 17-bit byte address and a write byte. It also has a response strobe that pulses for one cycle when an access has finished, and on a read it carries the fetched byte. On the memory side the controller drives the address, an active-low chip select and an active-high chip select, an active-low output enable and an active-low write enable. The shared data bus is split into an output byte, a drive enable and an input byte, which the pad ring joins into one tri-state bus.

Every memory timing window is stated in nanoseconds for two speed grades. Each window is turned into a whole number of clock cycles by rounding up the quotient of the time and the clock period. The parameter `SLOW_GRADE` chooses between the faster set (access and cycle 55 ns, output-enable access 25 ns, write pulse 40 ns, data setup 25 ns, bus release 20 ns) and the slower set (70 ns, 35 ns, 50 ns, 30 ns, 25 ns). A small phase machine moves through idle, setup, strobe, hold and turnaround. All memory pins come from registers, so write enable cannot glitch while the address settles.

Back-pressure rules: `req_ready` is high only while the controller is idle. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high, and its fields are sampled on that edge alone. The response has no back-pressure, and `rsp_valid` is a single-cycle strobe.

Top module: `asram_ctrl`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` is 0. Both chip selects are inactive (`mem_sel_n`=1, `mem_sel`=0), `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0.
- R2: `req_ready` is high only in the idle phase, and the chip selects are inactive while it is high. Address, write flag and data are taken on the accepting edge only. Changes to them while the controller is busy have no effect on the stored byte, and a request held valid while busy is not taken a second time.
- R3: A write (`req_write`=1) selects the memory and drives the data byte from the first cycle after acceptance. It holds `mem_we_n` low for ceil(WP/T) cycles with `mem_oe_n` high and keeps the byte driven for one cycle after `mem_we_n` rises. The data is therefore valid at least the data-setup time before write enable rises, and the pulse is at least the minimum write pulse.
- R4: A read (`req_write`=0) selects the memory with `mem_dq_oe` low and lowers `mem_oe_n`. It samples `mem_dq_in` only once the address access, chip-select access and output-enable access times have all elapsed, and no earlier than the read cycle time after the address was presented.
- R5: `rsp_valid` is high for exactly one cycle per accepted request. For a read, `rsp_rdata` holds the captured byte in that same cycle.
- R6: Counting the cycle that ends with the accepting edge as cycle 0, read `rsp_valid` is high in cycle 2 + max(ceil(AA/T)-1, ceil(OE/T), ceil(RC/T)-1). Write `rsp_valid` is high in cycle 3 + ceil(WP/T). At T = 5 ns on the fast grade these are 12 and 11.
- R7: After a read, `req_ready` returns ceil(HZ/T) cycles after the `rsp_valid` cycle. `mem_dq_oe` is never high while the memory drives the bus, nor within the bus-release time after it stops.
- R8: After a write, `req_ready` returns max(ceil(WC/T) - ceil(WP/T) - 2, 0) cycles after the `rsp_valid` cycle, which keeps the write cycle time.
- R9: `mem_oe_n` and `mem_we_n` are never low together. `mem_oe_n` falls only when `mem_dq_oe` was low in the cycle before, and `mem_addr` is stable while `mem_we_n` is low.
- R10: The whole 17-bit address space is reachable: bytes written at 0x00000 and 0x1FFFF read back independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8 | Byte read, valid with rsp_valid on reads |
| mem_addr | output | 17 | Memory address |
| mem_sel_n | output | 1 | Memory chip select, active low |
| mem_sel | output | 1 | Memory chip select, active high |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Byte seen on the data bus |

## Verification
A phase counter loaded with the wrong value shows at the ports within one access. The read response arrives a cycle early or late, or carries the filler value that the bench memory model returns before its access times have passed, and a short write pulse is flagged when write enable rises. A wrong turnaround state lets `mem_dq_oe` rise while the modelled memory may still drive, which is caught on the next falling clock edge. It also moves the return of `req_ready` by at least one cycle. A stale write-flag register shows as output enable and write enable low together, or as driving during a read, in the first strobe cycle.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_TURN
  } phase_e;

  // Active-high internal view of the memory control pins
  typedef struct packed {
    logic sel;
    logic oe;
    logic we;
    logic drive;
  } pin_ctl_t;

  function automatic int ns_to_cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_cnt.sv
`timescale 1ns/1ps
module asram_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
`timescale 1ns/1ps
module asram_fsm
  import asram_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int RD_STB  = 10,
  parameter int WR_STB  = 8,
  parameter int RD_TURN = 4,
  parameter int WR_TURN = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             req_write,
  input  logic             cnt_zero,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             idle,
  output pin_ctl_t         ctl_nxt,
  output logic             capture,
  output logic             done
);

  phase_e state_q, state_d;
  logic   wr_q, wr_d;
  logic   busy_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
    end
  end

  always_comb begin
    state_d  = state_q;
    wr_d     = wr_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    capture  = 1'b0;
    done     = 1'b0;
    case (state_q)
      PH_IDLE: begin
        if (req_fire) begin
          state_d  = PH_SETUP;
          wr_d     = req_write;
          cnt_load = 1'b1;
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          state_d  = PH_STROBE;
          cnt_load = 1'b1;
          cnt_val  = wr_q ? CNT_W'(WR_STB - 1) : CNT_W'(RD_STB - 1);
        end
      end
      PH_STROBE: begin
        if (cnt_zero) begin
          if (wr_q) begin
            state_d  = PH_HOLD;
            cnt_load = 1'b1;
          end else begin
            capture = 1'b1;
            done    = 1'b1;
            if (RD_TURN > 0) begin
              state_d  = PH_TURN;
              cnt_load = 1'b1;
              cnt_val  = CNT_W'(RD_TURN - 1);
            end else begin
              state_d = PH_IDLE;
            end
          end
        end
      end
      PH_HOLD: begin
        if (cnt_zero) begin
          done = 1'b1;
          if (WR_TURN > 0) begin
            state_d  = PH_TURN;
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(WR_TURN - 1);
          end else begin
            state_d = PH_IDLE;
          end
        end
      end
      PH_TURN: begin
        if (cnt_zero) state_d = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  // Pin controls follow the next phase so the pin registers line up with it
  assign busy_d        = (state_d == PH_SETUP) || (state_d == PH_STROBE) ||
                         (state_d == PH_HOLD);
  assign ctl_nxt.sel   = busy_d;
  assign ctl_nxt.oe    = (state_d == PH_STROBE) && !wr_d;
  assign ctl_nxt.we    = (state_d == PH_STROBE) && wr_d;
  assign ctl_nxt.drive = busy_d && wr_d;
  assign idle          = (state_q == PH_IDLE);

endmodule

// File: rtl/asram_pinreg.sv
`timescale 1ns/1ps
module asram_pinreg
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  pin_ctl_t          ctl_nxt,
  input  logic              capture,
  input  logic              done,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (latch) begin
      mem_addr   <= addr_in;
      mem_dq_out <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_sel_n <= 1'b1;
      mem_sel   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_sel_n <= !ctl_nxt.sel;
      mem_sel   <= ctl_nxt.sel;
      mem_oe_n  <= !ctl_nxt.oe;
      mem_we_n  <= !ctl_nxt.we;
      mem_dq_oe <= ctl_nxt.drive;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= done;
      if (capture) rsp_rdata <= dq_in;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter bit SLOW_GRADE    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  // Nanosecond minimums/maximums per speed grade
  localparam int NS_RC = SLOW_GRADE ? 70 : 55;
  localparam int NS_AA = SLOW_GRADE ? 70 : 55;
  localparam int NS_OE = SLOW_GRADE ? 35 : 25;
  localparam int NS_WC = SLOW_GRADE ? 70 : 55;
  localparam int NS_WP = SLOW_GRADE ? 50 : 40;
  localparam int NS_DW = SLOW_GRADE ? 30 : 25;
  localparam int NS_HZ = SLOW_GRADE ? 25 : 20;

  localparam int C_RC = ns_to_cyc(NS_RC, CLK_PERIOD_NS);
  localparam int C_AA = ns_to_cyc(NS_AA, CLK_PERIOD_NS);
  localparam int C_OE = ns_to_cyc(NS_OE, CLK_PERIOD_NS);
  localparam int C_WC = ns_to_cyc(NS_WC, CLK_PERIOD_NS);
  localparam int C_WP = ns_to_cyc(NS_WP, CLK_PERIOD_NS);
  localparam int C_DW = ns_to_cyc(NS_DW, CLK_PERIOD_NS);
  localparam int C_HZ = ns_to_cyc(NS_HZ, CLK_PERIOD_NS);

  // Setup phase is one cycle, so address time already has one cycle banked
  localparam int RD_STB  = max2(max2(C_AA - 1, C_OE), max2(C_RC - 1, 1));
  localparam int WR_STB  = max2(max2(C_WP, C_DW - 1), 1);
  localparam int RD_TURN = C_HZ;
  localparam int WR_TURN = max2(C_WC - WR_STB - 2, 0);
  localparam int MAX_CNT = max2(max2(RD_STB, WR_STB), max2(RD_TURN, WR_TURN));
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic             fire;
  logic             idle;
  logic             cnt_zero;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  pin_ctl_t         ctl_nxt;
  logic             capture;
  logic             done;

  assign req_ready = idle;
  assign fire      = req_valid && idle;

  asram_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  asram_fsm #(
    .CNT_W   (CNT_W),
    .RD_STB  (RD_STB),
    .WR_STB  (WR_STB),
    .RD_TURN (RD_TURN),
    .WR_TURN (WR_TURN)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (fire),
    .req_write (req_write),
    .cnt_zero  (cnt_zero),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .idle      (idle),
    .ctl_nxt   (ctl_nxt),
    .capture   (capture),
    .done      (done)
  );

  asram_pinreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch      (fire),
    .addr_in    (req_addr),
    .wdata_in   (req_wdata),
    .ctl_nxt    (ctl_nxt),
    .capture    (capture),
    .done       (done),
    .dq_in      (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  // R9
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);

  // R9
  oe_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  // R9
  addr_stable_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr));

  // R3
  we_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && !mem_sel_n && mem_sel));

  // R4
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R2
  ready_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && !mem_sel && !mem_dq_oe));

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_sel_n (mem_sel_n),
  .mem_sel   (mem_sel),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;

  localparam real HALF  = 2.5;
  localparam int  PER   = 5;
  localparam real AA_NS = 55.0;
  localparam real OE_NS = 25.0;
  localparam real WP_NS = 40.0;
  localparam real DW_NS = 25.0;
  localparam real HZ_NS = 20.0;

  function automatic int cdiv(input int ns);
    return (ns + PER - 1) / PER;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected cycle counts from the requirements (R6, R7, R8)
  localparam int RD_LAT = 2 + mx(mx(cdiv(55) - 1, cdiv(25)), cdiv(55) - 1);
  localparam int WR_LAT = 3 + cdiv(40);
  localparam int RD_GAP = cdiv(20);
  localparam int WR_GAP = mx(cdiv(55) - cdiv(40) - 2, 0);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n;
  logic [7:0]  mem_dq_out;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_in = 8'hEE;

  always #2.5 clk = ~clk;

  asram_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0;
  int n_fail = 0;
  int bus_viol = 0;
  int wr_viol = 0;
  int pin_viol = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] model [int];
  real t_addr = 0.0, t_sel = 0.0, t_oe = 0.0, t_wef = 0.0, t_dat = 0.0;
  real t_off = -1000.0;
  real now_t;
  wire selected = !mem_sel_n && mem_sel;
  wire mem_drv  = selected && !mem_oe_n && mem_we_n;

  always @(mem_addr)               t_addr = $realtime;
  always @(selected)               t_sel  = $realtime;
  always @(negedge mem_oe_n)       t_oe   = $realtime;
  always @(negedge mem_we_n)       t_wef  = $realtime;
  always @(mem_dq_out or mem_dq_oe) t_dat = $realtime;
  always @(negedge mem_drv)        t_off  = $realtime;

  function automatic logic [7:0] peek(input logic [16:0] a);
    return model.exists(int'(a)) ? model[int'(a)] : 8'h00;
  endfunction

  always @(negedge clk) begin
    now_t = $realtime + HALF;
    if (mem_drv && (now_t - t_addr >= AA_NS) && (now_t - t_sel >= AA_NS) &&
        (now_t - t_oe >= OE_NS))
      mem_dq_in = peek(mem_addr);
    else
      mem_dq_in = 8'hEE;
    if (rst_n && mem_dq_oe && (mem_drv || ($realtime - t_off < HZ_NS))) bus_viol++;
    if (rst_n && ((!mem_oe_n && !mem_we_n) || (!mem_oe_n && mem_dq_oe))) pin_viol++;
  end

  always @(posedge mem_we_n) begin
    if (rst_n && selected) begin
      if (($realtime - t_wef < WP_NS) || ($realtime - t_dat < DW_NS) || !mem_dq_oe)
        wr_viol++;
      model[int'(mem_addr)] = mem_dq_out;
    end
  end

  // ---------------- request helper ----------------
  task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d,
                       output int lat, output logic [7:0] rd, output int gap);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
    rd = rsp_rdata;
    gap = 0;
    while (!req_ready && gap < 100) begin
      @(negedge clk); gap++;
      if (gap == 1) check(!rsp_valid, "R5 pulse width", rsp_valid, 0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    check({mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe} == 5'b10110,
          "R1 pins", {mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
  endtask

  task automatic t_write_read(input logic [16:0] a, input logic [7:0] d);
    int lat, gap; logic [7:0] rd;
    do_op(1'b1, a, d, lat, rd, gap);
    check(lat == WR_LAT, "R6 write latency", lat, WR_LAT);
    check(gap == WR_GAP, "R8 write recovery", gap, WR_GAP);
    do_op(1'b0, a, 8'h00, lat, rd, gap);
    check(lat == RD_LAT, "R6 read latency", lat, RD_LAT);
    check(gap == RD_GAP, "R7 read turnaround", gap, RD_GAP);
    check(rd == d, "R4 R5 read data", rd, d);
  endtask

  task automatic t_range;
    int lat, gap; logic [7:0] rd;
    do_op(1'b1, 17'h00000, 8'h3C, lat, rd, gap);
    do_op(1'b1, 17'h1FFFF, 8'hC3, lat, rd, gap);
    do_op(1'b0, 17'h00000, 8'h00, lat, rd, gap);
    check(rd == 8'h3C, "R10 low address", rd, 8'h3C);
    do_op(1'b0, 17'h1FFFF, 8'h00, lat, rd, gap);
    check(rd == 8'hC3, "R10 top address", rd, 8'hC3);
  endtask

  task automatic t_backpressure;
    int busy_ready = 0, pulses = 0, lat, gap; logic [7:0] rd;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h0ABCD; req_wdata = 8'h5A;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_addr = 17'h00011; req_wdata = 8'hA5;
    for (int i = 0; i < WR_LAT - 1; i++) begin
      if (req_ready) busy_ready++;
      if (rsp_valid) pulses++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (rsp_valid) pulses++;
      @(negedge clk);
    end
    check(busy_ready == 0, "R2 ready low while busy", busy_ready, 0);
    check(pulses == 1, "R2 R5 single acceptance", pulses, 1);
    do_op(1'b0, 17'h0ABCD, 8'h00, lat, rd, gap);
    check(rd == 8'h5A, "R2 fields sampled at accept", rd, 8'h5A);
    do_op(1'b0, 17'h00011, 8'h00, lat, rd, gap);
    check(rd == 8'h00, "R2 late fields ignored", rd, 8'h00);
  endtask

  task automatic t_read_then_write;
    int lat, gap; logic [7:0] rd;
    do_op(1'b0, 17'h0ABCD, 8'h00, lat, rd, gap);
    do_op(1'b1, 17'h0ABCD, 8'h81, lat, rd, gap);
    do_op(1'b0, 17'h0ABCD, 8'h00, lat, rd, gap);
    check(rd == 8'h81, "R3 overwrite after read", rd, 8'h81);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_read(17'h00100, 8'hA5);
    t_write_read(17'h00101, 8'h00);
    t_write_read(17'h12345, 8'hFF);
    t_range();
    t_backpressure();
    t_read_then_write();
    check(bus_viol == 0, "R7 no bus contention", bus_viol, 0);
    check(wr_viol == 0, "R3 write pulse and setup", wr_viol, 0);
    check(pin_viol == 0, "R9 enable exclusion", pin_viol, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule